// File: doc/BRIEF.md
# Four-Lane Receive Deskew Controller

This block lines up four receive byte lanes that share one clock but arrive with different path delays. Each lane delivers a decoded byte, a valid strobe, an alignment-marker pulse and a clock-recovery lock flag. Every lane writes its bytes into a small circular buffer. A three-state machine watches for the markers and then sets the read pointers of all four lanes so that their marker bytes leave on the same output cycle.

Alignment is only attempted after every lane's lock flag has been held without a break for a programmable number of cycles. All four markers must land within a bounded skew window. Once alignment is reached, the relative read offsets are frozen. Any later marker traffic then shows up in the data but does not shift the lanes. Alignment is dropped when a lane loses lock or valid data, or when the channel-lock enable is withdrawn.

The reset input is asynchronous and active low, and is expected to be released synchronously to `clk`. The buffer depth must be a power of two.

Top module: `quad_lane_aligner`

## Requirements
- R1: While and just after reset, `sync_state_o` is 0 (no sync), `out_vld_o` is 0 and `lane_sync_o` is all zeros.
- R2: A marker is only accepted once all four `lane_lock_i` bits have been high on `QUAL_CYCLES` consecutive earlier clock edges. A marker seen with fewer edges behind it is ignored. A low bit on any lane restarts the count.
- R3: From no sync (0), the first accepted marker (a `lane_mark_i` bit with its `lane_vld_i` bit high) moves `sync_state_o` to 1 (re-sync) on that edge. Bit n of `lane_sync_o` goes high for each lane n whose marker has been accepted.
- R4: When every lane has shown a marker no more than `WINDOW` cycles after the first one, `sync_state_o` becomes 2 (in sync) on the edge of the last marker, and `lane_sync_o` is all ones.
- R5: If some lane has still not shown a marker `WINDOW` cycles after the first one, the state returns to 0 on that edge and `lane_sync_o` clears. A later marker starts a fresh attempt.
- R6: One cycle after the state becomes 2, `out_vld_o` is high and `out_data_o` holds each lane's marker byte (lane n in bits n*8+7..n*8). `out_mark_o` is all ones on that word.
- R7: While in state 2, further markers on any lanes, with any skew, leave the state unchanged. Each lane's output byte k cycles after the first word remains the byte that lane delivered k cycles after its own marker.
- R8: In state 2, a low `lane_lock_i` or `lane_vld_i` bit on any lane moves the state to 0 on that edge.
- R9: While `chan_lock_en_i` is low, the state goes to and stays at 0. After it is raised again, the state stays at 0 until new markers arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common lane clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data_i | input | NLANES*DW | Decoded byte per lane, lane n in bits n*DW+DW-1..n*DW |
| lane_vld_i | input | NLANES | Byte valid per lane |
| lane_mark_i | input | NLANES | Alignment marker seen on this byte, per lane |
| lane_lock_i | input | NLANES | Clock-recovery lock flag per lane |
| chan_lock_en_i | input | 1 | Channel-lock enable; low forces no sync |
| out_data_o | output | NLANES*DW | Aligned output word |
| out_vld_o | output | 1 | Aligned word valid |
| out_mark_o | output | NLANES | Marker flag carried with each output byte |
| lane_sync_o | output | NLANES | Per-lane marker-accepted status |
| sync_state_o | output | 2 | 0 no sync, 1 re-sync, 2 in sync |

## Verification
On every cycle, the assertions check these relations of the state machine: the qualification gate on leaving no sync, the upper bound on time spent in re-sync, the forced exits on lock, valid or enable loss, the all-ones lane status in sync, and the marker flags on the first valid word. Other properties depend on the data and can only be shown by the bench's scenarios. These include the exact byte that leads each lane after alignment, the frozen offsets when stray markers appear, and the acceptance or rejection of specific skew patterns, including the one at exactly the window limit.

// File: rtl/qla_pkg.sv
package qla_pkg;
  typedef enum logic [1:0] {
    ST_NOSYNC = 2'd0,
    ST_RESYNC = 2'd1,
    ST_INSYNC = 2'd2
  } sync_st_e;
endpackage

// File: rtl/qla_lock_qual.sv
// Counts consecutive cycles with every lane locked; arms once the limit is met.
module qla_lock_qual #(
  parameter int unsigned QUAL = 32000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_all_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  assign full = (cnt_q == CW'(QUAL));

  always_comb begin
    cnt_d = cnt_q;
    if (!lock_all_i)   cnt_d = '0;
    else if (!full)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed_o = full & lock_all_i;
endmodule

// File: rtl/qla_lane_buf.sv
// Per-lane circular buffer with a captured marker pointer.
module qla_lane_buf #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_mark_i,
  input  logic          cap_i,
  input  logic          load_i,
  input  logic          rd_i,
  output logic          empty_o,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_mark_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [DW:0]   mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d;
  logic [PW-1:0] rp_q, rp_d;
  logic [PW-1:0] mp_q, mp_d;

  always_comb begin
    wp_d = wp_q;
    if (wr_en_i) wp_d = wp_q + 1'b1;
    mp_d = cap_i ? wp_q : mp_q;
    rp_d = rp_q;
    if (load_i)    rp_d = mp_d;
    else if (rd_i) rp_d = rp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      mp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      mp_q <= mp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wp_q[AW-1:0]] <= {wr_mark_i, wr_data_i};
  end

  assign empty_o   = (wp_q == rp_q);
  assign rd_data_o = mem[rp_q[AW-1:0]][DW-1:0];
  assign rd_mark_o = mem[rp_q[AW-1:0]][DW];
endmodule

// File: rtl/qla_sync_fsm.sv
// Three-state alignment machine with skew-window timer.
module qla_sync_fsm
  import qla_pkg::*;
#(
  parameter int unsigned NL     = 4,
  parameter int unsigned WINDOW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qual_i,
  input  logic [NL-1:0] mark_i,
  input  logic [NL-1:0] lock_i,
  input  logic [NL-1:0] vld_i,
  output sync_st_e      state_o,
  output logic [NL-1:0] seen_o,
  output logic [NL-1:0] cap_o,
  output logic          load_o
);
  localparam int unsigned WW = $clog2(WINDOW + 1);

  sync_st_e      st_q, st_d;
  logic [NL-1:0] seen_q, seen_d;
  logic [WW-1:0] win_q, win_d;
  logic          load;
  logic [NL-1:0] seen_any;

  assign seen_any = seen_q | mark_i;

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    win_d  = win_q;
    load   = 1'b0;
    unique case (st_q)
      ST_NOSYNC: begin
        seen_d = '0;
        win_d  = '0;
        if (qual_i && (|mark_i)) begin
          seen_d = mark_i;
          win_d  = WW'(1);
          if (&mark_i) begin
            st_d = ST_INSYNC;
            load = 1'b1;
          end else begin
            st_d = ST_RESYNC;
          end
        end
      end
      ST_RESYNC: begin
        if (!qual_i) begin
          st_d   = ST_NOSYNC;
          seen_d = '0;
          win_d  = '0;
        end else if (&seen_any) begin
          st_d   = ST_INSYNC;
          seen_d = seen_any;
          load   = 1'b1;
        end else if (win_q >= WW'(WINDOW)) begin
          st_d   = ST_NOSYNC;
          seen_d = '0;
          win_d  = '0;
        end else begin
          win_d  = win_q + 1'b1;
          seen_d = seen_any;
        end
      end
      ST_INSYNC: begin
        if (!qual_i || !(&lock_i) || !(&vld_i)) begin
          st_d   = ST_NOSYNC;
          seen_d = '0;
          win_d  = '0;
        end
      end
      default: begin
        st_d   = ST_NOSYNC;
        seen_d = '0;
        win_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_NOSYNC;
      seen_q <= '0;
      win_q  <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      win_q  <= win_d;
    end
  end

  assign cap_o   = (qual_i && st_q != ST_INSYNC) ? (mark_i & ~seen_q) : '0;
  assign load_o  = load;
  assign state_o = st_q;
  assign seen_o  = seen_q;
endmodule

// File: rtl/quad_lane_aligner.sv
module quad_lane_aligner
  import qla_pkg::*;
#(
  parameter int unsigned NLANES      = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned WINDOW      = 4,
  parameter int unsigned QUAL_CYCLES = 32000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NLANES*DW-1:0] lane_data_i,
  input  logic [NLANES-1:0]    lane_vld_i,
  input  logic [NLANES-1:0]    lane_mark_i,
  input  logic [NLANES-1:0]    lane_lock_i,
  input  logic                 chan_lock_en_i,
  output logic [NLANES*DW-1:0] out_data_o,
  output logic                 out_vld_o,
  output logic [NLANES-1:0]    out_mark_o,
  output logic [NLANES-1:0]    lane_sync_o,
  output logic [1:0]           sync_state_o
);
  logic                 armed;
  logic                 qual;
  logic [NLANES-1:0]    mark_v;
  sync_st_e             state;
  logic [NLANES-1:0]    seen;
  logic [NLANES-1:0]    cap;
  logic                 load;
  logic [NLANES-1:0]    empty;
  logic [NLANES*DW-1:0] rdata;
  logic [NLANES-1:0]    rmark;
  logic                 rd_all;

  logic [NLANES*DW-1:0] out_data_q;
  logic [NLANES-1:0]    out_mark_q;
  logic                 out_vld_q;

  assign mark_v = lane_mark_i & lane_vld_i;
  assign qual   = armed & chan_lock_en_i;

  qla_lock_qual #(.QUAL(QUAL_CYCLES)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_all_i (&lane_lock_i),
    .armed_o    (armed)
  );

  qla_sync_fsm #(.NL(NLANES), .WINDOW(WINDOW)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (qual),
    .mark_i  (mark_v),
    .lock_i  (lane_lock_i),
    .vld_i   (lane_vld_i),
    .state_o (state),
    .seen_o  (seen),
    .cap_o   (cap),
    .load_o  (load)
  );

  assign rd_all = (state == ST_INSYNC) && !(|empty);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    qla_lane_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (lane_vld_i[g]),
      .wr_data_i (lane_data_i[g*DW +: DW]),
      .wr_mark_i (lane_mark_i[g]),
      .cap_i     (cap[g]),
      .load_i    (load),
      .rd_i      (rd_all),
      .empty_o   (empty[g]),
      .rd_data_o (rdata[g*DW +: DW]),
      .rd_mark_o (rmark[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld_q  <= 1'b0;
      out_data_q <= '0;
      out_mark_q <= '0;
    end else begin
      out_vld_q <= rd_all;
      if (rd_all) begin
        out_data_q <= rdata;
        out_mark_q <= rmark;
      end
    end
  end

  assign out_data_o   = out_data_q;
  assign out_vld_o    = out_vld_q;
  assign out_mark_o   = out_mark_q;
  assign lane_sync_o  = seen;
  assign sync_state_o = state;
endmodule

module qla_checker #(
  parameter int unsigned NL     = 4,
  parameter int unsigned WINDOW = 4,
  parameter int unsigned QUAL   = 32000
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NL-1:0] lane_vld_i,
  input logic [NL-1:0] lane_mark_i,
  input logic [NL-1:0] lane_lock_i,
  input logic          chan_lock_en_i,
  input logic          out_vld_o,
  input logic [NL-1:0] out_mark_o,
  input logic [NL-1:0] lane_sync_o,
  input logic [1:0]    sync_state_o
);
  localparam int unsigned QCW = $clog2(QUAL + 1) + 1;
  localparam int unsigned RCW = $clog2(WINDOW + 1) + 1;

  logic [QCW-1:0] qcnt;
  logic [RCW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 qcnt <= '0;
    else if (!(&lane_lock_i))   qcnt <= '0;
    else if (qcnt < QCW'(QUAL)) qcnt <= qcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rcnt <= '0;
    else if (sync_state_o == 2'd1) rcnt <= rcnt + 1'b1;
    else                         rcnt <= '0;
  end

  // R2
  qual_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state_o == 2'd0 && (qcnt < QCW'(QUAL) || !(&lane_lock_i))) |=> (sync_state_o == 2'd0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state_o == 2'd0 && !(|(lane_mark_i & lane_vld_i))) |=> (sync_state_o == 2'd0));

  // R4
  insync_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state_o == 2'd2) |-> (lane_sync_o == {NL{1'b1}}));

  // R5
  window_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state_o == 2'd1 && rcnt == RCW'(WINDOW - 1)) |=> (sync_state_o != 2'd1));

  // R6
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !$past(out_vld_o)) |-> (out_mark_o == {NL{1'b1}}));

  // R6
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> ($past(sync_state_o) == 2'd2));

  // R8
  loss_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state_o == 2'd2 && (!(&lane_lock_i) || !(&lane_vld_i))) |=> (sync_state_o == 2'd0));

  // R9
  enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_lock_en_i |=> (sync_state_o == 2'd0));
endmodule

bind quad_lane_aligner qla_checker #(
  .NL(NLANES), .WINDOW(WINDOW), .QUAL(QUAL_CYCLES)
) u_qla_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lane_vld_i     (lane_vld_i),
  .lane_mark_i    (lane_mark_i),
  .lane_lock_i    (lane_lock_i),
  .chan_lock_en_i (chan_lock_en_i),
  .out_vld_o      (out_vld_o),
  .out_mark_o     (out_mark_o),
  .lane_sync_o    (lane_sync_o),
  .sync_state_o   (sync_state_o)
);

// File: tb/quad_lane_aligner_bench.sv
module quad_lane_aligner_bench;
  localparam int NL = 4, DW = 8, DEPTH = 8, WIN = 4, QUAL = 20;

  logic            clk;
  logic            rst_n;
  logic [NL*DW-1:0] lane_data;
  logic [NL-1:0]   lane_vld, lane_mark, lane_lock;
  logic            en;
  logic [NL*DW-1:0] out_data;
  logic            out_vld;
  logic [NL-1:0]   out_mark, lane_sync;
  logic [1:0]      state;

  quad_lane_aligner #(.NLANES(NL), .DW(DW), .DEPTH(DEPTH), .WINDOW(WIN), .QUAL_CYCLES(QUAL))
  u_quad_lane_aligner (
    .clk(clk), .rst_n(rst_n), .lane_data_i(lane_data), .lane_vld_i(lane_vld),
    .lane_mark_i(lane_mark), .lane_lock_i(lane_lock), .chan_lock_en_i(en),
    .out_data_o(out_data), .out_vld_o(out_vld), .out_mark_o(out_mark),
    .lane_sync_o(lane_sync), .sync_state_o(state)
  );

  int total = 0, bad = 0, cyc = 0, nfirst = 0;
  int mcyc [NL];

  // {expect aligned, skew lane3, lane2, lane1, lane0}
  localparam logic [16:0] VEC [6] = '{
    17'h1_0000, 17'h1_3210, 17'h1_1204, 17'h1_4322, 17'h0_5100, 17'h0_1770
  };

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    for (int l = 0; l < NL; l++) lane_data[l*DW +: DW] <= {2'(l), 6'(cyc + 1)};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_marks(input logic [15:0] sk, input bit rec);
    int mx = 0;
    for (int l = 0; l < NL; l++) if (int'(sk[l*4 +: 4]) > mx) mx = int'(sk[l*4 +: 4]);
    for (int d = 0; d <= mx; d++) begin
      for (int l = 0; l < NL; l++) begin
        lane_mark[l] = (int'(sk[l*4 +: 4]) == d);
        if (rec && lane_mark[l]) mcyc[l] = cyc + 1;
      end
      @(negedge clk);
    end
    lane_mark = '0;
  endtask

  task automatic check_words(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk({tag, " valid"}, int'(out_vld), 1);
      for (int l = 0; l < NL; l++)
        chk({tag, " lane byte"}, int'(out_data[l*DW +: DW]),
            int'({2'(l), 6'(mcyc[l] + cyc - nfirst)}));
      @(negedge clk);
    end
  endtask

  task automatic en_cycle();
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] mx;
    logic [NL-1:0] late;
    rst_n = 1'b0; lane_vld = '1; lane_mark = '0; lane_lock = '0; en = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(state), 0);
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 lane_sync", int'(lane_sync), 0);
    rst_n = 1'b1;

    // R2 qualification with a restart
    lane_lock = '1;
    repeat (8) @(negedge clk);
    lane_lock[2] = 1'b0;
    @(negedge clk);
    lane_lock = '1;
    repeat (QUAL - 1) @(negedge clk);
    lane_mark = '1;
    @(negedge clk);
    lane_mark = '0;
    chk("R2 early marker ignored", int'(state), 0);
    chk("R2 lane_sync idle", int'(lane_sync), 0);
    lane_mark = 4'b0001;
    @(negedge clk);
    lane_mark = '0;
    // R3 first accepted marker
    chk("R3 state resync", int'(state), 1);
    chk("R3 lane_sync", int'(lane_sync), 1);
    en_cycle();

    // table of skew patterns (R4, R5, R6)
    for (int i = 0; i < 6; i++) begin
      en_cycle();
      run_marks(VEC[i][15:0], 1'b1);
      if (VEC[i][16]) begin
        chk("R4 aligned state", int'(state), 2);
        chk("R4 lane_sync", int'(lane_sync), 15);
        @(negedge clk);
        nfirst = cyc;
        chk("R6 first marks", int'(out_mark), 15);
        check_words(3, "R6");
      end else begin
        mx = 0; late = '0;
        for (int l = 0; l < NL; l++) if (VEC[i][l*4 +: 4] > mx) mx = VEC[i][l*4 +: 4];
        for (int l = 0; l < NL; l++) late[l] = (VEC[i][l*4 +: 4] == mx);
        chk("R5 late lanes restart", int'(state), 1);
        chk("R5 late lane_sync", int'(lane_sync), int'(late));
      end
    end

    // R5 exact expiry timing
    en_cycle();
    lane_mark = 4'b0111;
    @(negedge clk);
    lane_mark = '0;
    chk("R3 partial lane_sync", int'(lane_sync), 7);
    repeat (WIN - 1) @(negedge clk);
    chk("R5 still resync", int'(state), 1);
    @(negedge clk);
    chk("R5 expired", int'(state), 0);
    chk("R5 lane_sync cleared", int'(lane_sync), 0);

    // R7 frozen skew
    en_cycle();
    run_marks(16'h3210, 1'b1);
    @(negedge clk);
    nfirst = cyc;
    check_words(2, "R7 pre");
    lane_mark = 4'b0001;
    @(negedge clk);
    lane_mark = '0;
    chk("R7 state after stray", int'(state), 2);
    check_words(2, "R7 post single");
    run_marks(16'h0003, 1'b0);
    chk("R7 state after skewed markers", int'(state), 2);
    check_words(3, "R7 post skewed");

    // R8 lock loss
    lane_lock[1] = 1'b0;
    @(negedge clk);
    lane_lock = '1;
    chk("R8 lock loss", int'(state), 0);
    repeat (QUAL) @(negedge clk);
    run_marks(16'h0000, 1'b1);
    chk("R8 resync after requal", int'(state), 2);
    lane_vld[3] = 1'b0;
    @(negedge clk);
    lane_vld = '1;
    chk("R8 valid loss", int'(state), 0);

    // R9 enable withdrawal
    run_marks(16'h0000, 1'b1);
    chk("R9 pre aligned", int'(state), 2);
    en = 1'b0;
    @(negedge clk);
    chk("R9 forced nosync", int'(state), 0);
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 stays nosync", int'(state), 0);
    run_marks(16'h1010, 1'b1);
    chk("R9 realign", int'(state), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule